// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in in pure combinational logic. The operands are split into four slices of four bits. Every bit forms its own carry-generate term (both bits set) and carry-propagate term (either bit set). A lookahead unit per slice turns those terms into the carries for its own bits. It also produces one slice-wide propagate term and one slice-wide generate term.

A second lookahead unit of the same kind reads the four slice-wide pairs and the block carry-in. From them it derives the carry into each slice directly, so no carry ripples from slice to slice. The same unit also yields a block-wide propagate and generate pair. These two outputs let a parent adder treat this block as one group in a further level of lookahead. The final carry-out is formed from that pair and the carry-in.

There is no state in this block, so the state-machine layout of the house style does not apply. Its naming, indentation and checker layout are kept.

Top module: `cla_adder16`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, for any operands.
- R2: `carry_out` equals bit 16 of the 17-bit value `op_a + op_b + carry_in`.
- R3: `blk_gen` is 1 exactly when `op_a + op_b` with a carry-in of 0 overflows 16 bits.
- R4: `blk_prop` is 1 exactly when every bit position has at least one operand bit set, that is the AND over i of (op_a[i] OR op_b[i]).
- R5: `carry_out` equals `blk_gen OR (blk_prop AND carry_in)` for every input.
- R6: all-ones plus all-ones with a carry-in of 1 gives `sum_out` 16'hFFFF and `carry_out` 1.
- R7: a carry-in of 1 into operands 16'hFFFF and 16'h0000 travels through all four slices, giving `sum_out` 0 and `carry_out` 1. With a carry-in of 0 the same operands give 16'hFFFF and 0.
- R8: a carry leaving any slice lands in bit 0 of the next slice. For example, 16'h000F + 1 gives 16'h0010, 16'h00FF + 1 gives 16'h0100, and 16'h0FFF + 1 gives 16'h1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | first operand |
| op_b | input | 16 | second operand |
| carry_in | input | 1 | carry into bit 0 |
| sum_out | output | 16 | low 16 bits of the sum |
| carry_out | output | 1 | carry out of bit 15 |
| blk_prop | output | 1 | block-wide propagate term, for cascading |
| blk_gen | output | 1 | block-wide generate term, for cascading |

## Verification
The bench builds the adder with its defaults: four slices of four bits each. This puts the three slice edges at bits 4, 8 and 12 inside the operand range. Directed runs of ones that end at each edge, together with all-ones and all-zeros operands, exercise both the slice carries formed by the second-level unit and the carry into bit 0 of every slice. Seeded random operands then cover mixed generate and propagate patterns, and each vector is checked against a 17-bit reference sum.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // bits in one lookahead slice
    parameter int unsigned SLICE_W = 4;
    // slices in the block
    parameter int unsigned SLICE_N = 4;
    parameter int unsigned ADD_W   = SLICE_W * SLICE_N;
endpackage

// File: rtl/cla_bitcell.sv
// Per-bit carry terms and half-sum for a vector of bit positions.
module cla_bitcell #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] gen_b,
    output logic [W-1:0] prop_b,
    output logic [W-1:0] half_b
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign gen_b[i]  = x[i] & y[i];
            assign prop_b[i] = x[i] | y[i];
            assign half_b[i] = x[i] ^ y[i];
        end
    endgenerate
endmodule

// File: rtl/cla_lookahead.sv
// Lookahead unit: carries into each position as flat sums of products,
// plus the unit-wide propagate and generate terms.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] pin,
    input  logic [N-1:0] gin,
    input  logic         cin,
    output logic [N-1:0] cpos,
    output logic         unit_p,
    output logic         unit_g
);
    logic gsum;
    logic pchain;

    always_comb begin
        cpos[0] = cin;
        for (int i = 1; i < N; i++) begin
            gsum   = 1'b0;
            pchain = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                gsum   = gsum | (gin[j] & pchain);
                pchain = pchain & pin[j];
            end
            cpos[i] = gsum | (pchain & cin);
        end
        gsum   = 1'b0;
        pchain = 1'b1;
        for (int j = N - 1; j >= 0; j--) begin
            gsum   = gsum | (gin[j] & pchain);
            pchain = pchain & pin[j];
        end
        unit_g = gsum;
        unit_p = pchain;
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W = SLICE_W,
    parameter int unsigned GRP_N = SLICE_N,
    localparam int unsigned W    = GRP_W * GRP_N
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         blk_prop,
    output logic         blk_gen
);
    logic [W-1:0]     bit_g;
    logic [W-1:0]     bit_p;
    logic [W-1:0]     bit_h;
    logic [W-1:0]     bit_c;
    logic [GRP_N-1:0] grp_p;
    logic [GRP_N-1:0] grp_g;
    logic [GRP_N-1:0] grp_c;

    cla_bitcell #(.W(W)) u_cells (
        .x      (op_a),
        .y      (op_b),
        .gen_b  (bit_g),
        .prop_b (bit_p),
        .half_b (bit_h)
    );

    genvar k;
    generate
        for (k = 0; k < GRP_N; k++) begin : g_slice
            cla_lookahead #(.N(GRP_W)) u_la1 (
                .pin    (bit_p[k*GRP_W +: GRP_W]),
                .gin    (bit_g[k*GRP_W +: GRP_W]),
                .cin    (grp_c[k]),
                .cpos   (bit_c[k*GRP_W +: GRP_W]),
                .unit_p (grp_p[k]),
                .unit_g (grp_g[k])
            );
        end
    endgenerate

    // second level: slice carries straight from slice terms
    cla_lookahead #(.N(GRP_N)) u_la2 (
        .pin    (grp_p),
        .gin    (grp_g),
        .cin    (carry_in),
        .cpos   (grp_c),
        .unit_p (blk_prop),
        .unit_g (blk_gen)
    );

    assign sum_out   = bit_h ^ bit_c;
    assign carry_out = blk_gen | (blk_prop & carry_in);
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
    parameter int unsigned W = 16
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic [W-1:0] sum_out,
    input logic         carry_out,
    input logic         blk_prop,
    input logic         blk_gen
);
    logic [W:0] full_ref;
    logic [W:0] nocin_ref;

    always_comb begin
        full_ref  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
        nocin_ref = {1'b0, op_a} + {1'b0, op_b};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            // R1
            sum_match_chk: assert (sum_out == full_ref[W-1:0])
                else $error("sum mismatch");
            // R2
            carry_match_chk: assert (carry_out == full_ref[W])
                else $error("carry mismatch");
            // R3
            gen_match_chk: assert (blk_gen == nocin_ref[W])
                else $error("generate mismatch");
            // R4
            prop_match_chk: assert (blk_prop == &(op_a | op_b))
                else $error("propagate mismatch");
        end
    end
endmodule

bind cla_adder16 cla_adder16_chk #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .blk_prop  (blk_prop),
    .blk_gen   (blk_gen)
);

// File: tb/test_cla_adder16.sv
module test_cla_adder16;
    logic        clk = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        ci = 1'b0;
    logic [15:0] s_o;
    logic        co, bp, bg;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cla_adder16 i_cla_adder16 (
        .op_a      (a_in),
        .op_b      (b_in),
        .carry_in  (ci),
        .sum_out   (s_o),
        .carry_out (co),
        .blk_prop  (bp),
        .blk_gen   (bg)
    );

    function automatic logic [16:0] ref_sum(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    function automatic logic ref_prop(logic [15:0] x, logic [15:0] y);
        return &(x | y);
    endfunction

    task automatic chk(bit ok, string tag, logic [16:0] act, logic [16:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive after a rising edge, sample at the following falling edge
    task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
        logic [16:0] e, e0;
        @(posedge clk);
        a_in = x; b_in = y; ci = c;
        @(negedge clk);
        e  = ref_sum(x, y, c);
        e0 = ref_sum(x, y, 1'b0);
        chk(s_o == e[15:0], "R1 sum", {1'b0, s_o}, {1'b0, e[15:0]});
        chk(co == e[16], "R2 carry", {16'd0, co}, {16'd0, e[16]});
        chk(bg == e0[16], "R3 gen", {16'd0, bg}, {16'd0, e0[16]});
        chk(bp == ref_prop(x, y), "R4 prop", {16'd0, bp}, {16'd0, ref_prop(x, y)});
        chk(co == (bg | (bp & c)), "R5 combine", {16'd0, co}, {16'd0, bg | (bp & c)});
    endtask

    initial begin
        void'($urandom(32'd4242));
        // quiet-input state
        @(negedge clk);
        chk(s_o == 16'h0 && co == 1'b0, "R1 zero inputs", {co, s_o}, 17'h0);
        // R6
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        chk({co, s_o} == 17'h1FFFF, "R6 all ones", {co, s_o}, 17'h1FFFF);
        // R7
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk({co, s_o} == 17'h10000, "R7 cin through", {co, s_o}, 17'h10000);
        apply(16'hFFFF, 16'h0000, 1'b0);
        chk({co, s_o} == 17'h0FFFF, "R7 no cin", {co, s_o}, 17'h0FFFF);
        // R8 slice edges
        apply(16'h000F, 16'h0001, 1'b0);
        chk(s_o == 16'h0010, "R8 edge4", {1'b0, s_o}, 17'h00010);
        apply(16'h00FF, 16'h0001, 1'b0);
        chk(s_o == 16'h0100, "R8 edge8", {1'b0, s_o}, 17'h00100);
        apply(16'h0FFF, 16'h0000, 1'b1);
        chk(s_o == 16'h1000, "R8 edge12", {1'b0, s_o}, 17'h01000);
        apply(16'h8000, 16'h8000, 1'b0);
        apply(16'h5555, 16'hAAAA, 1'b0);
        apply(16'h5555, 16'hAAAA, 1'b1);
        for (int n = 0; n < 400; n++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule